// File: doc/BRIEF.md
# Scan-out Engine for a 640x480 Display Fed from a Clock-Crossing Pixel Queue

This block generates the raster timing for a 640x480 display on its own pixel clock. On each active-video clock it pulls one 16-bit pixel from an internal dual-clock queue and presents it at the output in step with the sync and data-enable signals. Outside the visible area the pixel output is black and the queue is not read.

A producer in the system clock domain fills the queue through a plain write port. The port has a full indication for backpressure. Once per frame the block raises a one-cycle request pulse in the system domain. That pulse tells the producer to push the next frame's pixels in raster order. The producer may write in bursts faster than the pixel rate and then stall for a while, and the queue absorbs the difference.

The request is derived from the horizontal blanking flag. That flag is carried through a flip-flop chain into the system domain and combined with a compare on the line counter during the last vertical sync line. This gives the producer the back porch as a head start. If the queue is empty when a visible pixel is due, a black pixel is shown and a sticky underflow flag is set.

Top module: `vga_fifo_scanout`

## Requirements
- R1: Each line is 800 pixel clocks long. `hsync_n` is low for horizontal positions 656 to 751 and high for all others.
- R2: Each frame is 525 lines long. `vsync_n` is low during lines 490 and 491 and high for all others.
- R3: `video_de` is high exactly when the horizontal position is below 640 and the line is below 480. During those clocks one queued pixel is taken per clock and presented on `pixel`, in the order it was written. The sync outputs never go low while `video_de` is high.
- R4: Outside the visible area, `pixel` is 0 and no entry is taken from the queue. The first pixel of the next visible line is therefore the next word that was written.
- R5: `frame_req` is high for exactly one system clock per frame. It rises after horizontal blanking starts in line 491, the last sync line, and before that line ends.
- R6: The producer may write with any pattern of gaps, and with bursts longer than the queue depth by holding off while `px_wr_full` is high. Every written pixel is then shown exactly once, at its raster position.
- R7: If the queue is empty when a visible pixel is due, `pixel` shows 0 for that clock and `underflow` goes high and stays high until reset.
- R8: While reset is low, `hsync_n` and `vsync_n` are 1 and `video_de`, `pixel`, `underflow` and `frame_req` are 0. Scan-out starts at position 0 of line 491, so the first request comes before the first visible line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock, producer side |
| clk_pix | input | 1 | Pixel clock, asynchronous to clk_sys |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| px_wr_en | input | 1 | Write strobe for one pixel (clk_sys) |
| px_wr_data | input | 16 | Pixel word to write (clk_sys) |
| px_wr_full | output | 1 | Queue full; writes are dropped while high (clk_sys) |
| frame_req | output | 1 | One-cycle request for the next frame (clk_sys) |
| hsync_n | output | 1 | Horizontal sync, active low (clk_pix) |
| vsync_n | output | 1 | Vertical sync, active low (clk_pix) |
| video_de | output | 1 | Visible-area data enable (clk_pix) |
| pixel | output | 16 | Pixel value, black outside the visible area (clk_pix) |
| underflow | output | 1 | Sticky flag: a visible pixel found the queue empty (clk_pix) |

## Verification
A pixel pop on the display side and a push by the producer can fall in the same moment on a nearly drained queue. The small bench configuration gives only one back-porch line of head start, and one frame is written as a burst larger than the queue depth. As a result, pops near the start of each frame race the pushes that are still arriving. Each frame is judged by comparing every pixel clock against the arithmetically expected word, sync level and enable. A single early, late, duplicated or missing pop therefore shows up as a shifted pixel value. A deliberately short last frame then lets the empty case coincide with a due pixel, and the bench checks for black output and the sticky flag from that clock onward.

// File: rtl/vga_scan_pkg.sv
package vga_scan_pkg;

  localparam int unsigned PIX_W = 16;

  typedef logic [PIX_W-1:0] pixel_t;

  // gray encoding of a binary pointer
  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

endpackage

// File: rtl/vga_rst_sync.sv
module vga_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = chain_q[STAGES-1];

endmodule

// File: rtl/vga_async_fifo.sv
module vga_async_fifo #(
  parameter int unsigned W      = 16,
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned SYNC   = 2
) (
  input  logic         wclk,
  input  logic         wrst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         wr_full,
  input  logic         rclk,
  input  logic         rrst_n,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         rd_empty
);
  import vga_scan_pkg::*;

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wbin_q, wbin_d, wgray_q, wgray_d;
  logic [PW-1:0] rbin_q, rbin_d, rgray_q, rgray_d;
  logic [PW-1:0] rgray_w [SYNC];
  logic [PW-1:0] wgray_r [SYNC];
  logic          push, pop;

  // ---------------- write side ----------------
  assign wr_full = (wgray_q == {~rgray_w[SYNC-1][PW-1:PW-2], rgray_w[SYNC-1][PW-3:0]});
  assign push    = wr_en & ~wr_full;

  always_comb begin
    wbin_d  = wbin_q;
    if (push) wbin_d = wbin_q + 1'b1;
    wgray_d = PW'(bin2gray(32'(wbin_d)));
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  always_ff @(posedge wclk) begin
    if (push) mem[wbin_q[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      for (int i = 0; i < SYNC; i++) rgray_w[i] <= '0;
    end else begin
      rgray_w[0] <= rgray_q;
      for (int i = 1; i < SYNC; i++) rgray_w[i] <= rgray_w[i-1];
    end
  end

  // ---------------- read side ----------------
  assign rd_empty = (rgray_q == wgray_r[SYNC-1]);
  assign pop      = rd_en & ~rd_empty;
  assign rd_data  = mem[rbin_q[AW-1:0]];

  always_comb begin
    rbin_d  = rbin_q;
    if (pop) rbin_d = rbin_q + 1'b1;
    rgray_d = PW'(bin2gray(32'(rbin_d)));
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
    end
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      for (int i = 0; i < SYNC; i++) wgray_r[i] <= '0;
    end else begin
      wgray_r[0] <= wgray_q;
      for (int i = 1; i < SYNC; i++) wgray_r[i] <= wgray_r[i-1];
    end
  end

  // R7
  no_pop_when_empty_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    rd_en |-> !rd_empty);

endmodule

// File: rtl/vga_raster_timing.sv
module vga_raster_timing #(
  parameter int unsigned W     = 16,
  parameter int unsigned H_ACT = 640,
  parameter int unsigned H_FP  = 16,
  parameter int unsigned H_SW  = 96,
  parameter int unsigned H_BP  = 48,
  parameter int unsigned V_ACT = 480,
  parameter int unsigned V_FP  = 10,
  parameter int unsigned V_SW  = 2,
  parameter int unsigned V_BP  = 33,
  localparam int unsigned H_TOT = H_ACT + H_FP + H_SW + H_BP,
  localparam int unsigned V_TOT = V_ACT + V_FP + V_SW + V_BP,
  localparam int unsigned HW    = $clog2(H_TOT),
  localparam int unsigned VW    = $clog2(V_TOT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  fifo_data,
  input  logic          fifo_empty,
  output logic          fifo_pop,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          video_de,
  output logic [W-1:0]  pixel,
  output logic          underflow,
  output logic          hblank,
  output logic [VW-1:0] vcount
);

  localparam logic [HW-1:0] H_ACT_C  = HW'(H_ACT);
  localparam logic [HW-1:0] H_SS_C   = HW'(H_ACT + H_FP);
  localparam logic [HW-1:0] H_SE_C   = HW'(H_ACT + H_FP + H_SW);
  localparam logic [HW-1:0] H_LAST_C = HW'(H_TOT - 1);
  localparam logic [VW-1:0] V_ACT_C  = VW'(V_ACT);
  localparam logic [VW-1:0] V_SS_C   = VW'(V_ACT + V_FP);
  localparam logic [VW-1:0] V_SE_C   = VW'(V_ACT + V_FP + V_SW);
  localparam logic [VW-1:0] V_LAST_C = VW'(V_TOT - 1);
  localparam logic [VW-1:0] V_INIT_C = VW'(V_ACT + V_FP + V_SW - 1);

  logic [HW-1:0] h_q, h_d;
  logic [VW-1:0] v_q, v_d;
  logic          hs_q, hs_d, vs_q, vs_d, de_q, de_d;
  logic          uf_q, uf_d, hb_q, hb_d;
  logic [W-1:0]  pix_q, pix_d;
  logic          active, line_end;

  // next-state logic
  always_comb begin
    line_end = (h_q == H_LAST_C);
    h_d      = line_end ? '0 : h_q + 1'b1;
    v_d      = v_q;
    if (line_end) v_d = (v_q == V_LAST_C) ? '0 : v_q + 1'b1;

    active   = (h_q < H_ACT_C) && (v_q < V_ACT_C);
    fifo_pop = active & ~fifo_empty;

    hs_d  = !((h_q >= H_SS_C) && (h_q < H_SE_C));
    vs_d  = !((v_q >= V_SS_C) && (v_q < V_SE_C));
    de_d  = active;
    pix_d = fifo_pop ? fifo_data : '0;
    uf_d  = uf_q | (active & fifo_empty);
    hb_d  = (h_q >= H_ACT_C);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q   <= '0;
      v_q   <= V_INIT_C;
      hs_q  <= 1'b1;
      vs_q  <= 1'b1;
      de_q  <= 1'b0;
      pix_q <= '0;
      uf_q  <= 1'b0;
      hb_q  <= 1'b0;
    end else begin
      h_q   <= h_d;
      v_q   <= v_d;
      hs_q  <= hs_d;
      vs_q  <= vs_d;
      de_q  <= de_d;
      pix_q <= pix_d;
      uf_q  <= uf_d;
      hb_q  <= hb_d;
    end
  end

  assign hsync_n   = hs_q;
  assign vsync_n   = vs_q;
  assign video_de  = de_q;
  assign pixel     = pix_q;
  assign underflow = uf_q;
  assign hblank    = hb_q;
  assign vcount    = v_q;

  // R3
  sync_idle_in_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de_q |-> (hs_q && vs_q));

  // R4
  black_outside_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !de_q |-> (pix_q == '0));

  // R7
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uf_q |=> uf_q);

  // R1
  hblank_covers_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_q |-> hb_q);

endmodule

// File: rtl/vga_frame_request.sv
module vga_frame_request #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned VW     = 10,
  parameter int unsigned V_TRIG = 491
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hblank_async,
  input  logic [VW-1:0] vcount_async,
  output logic          frame_req
);

  localparam logic [VW-1:0] V_TRIG_C = VW'(V_TRIG);

  logic [STAGES:0] hb_sync_q;
  logic            rise, req_d, req_q;

  // vcount only changes far from the hblank rising edge, so it is sampled directly
  always_comb begin
    rise  = hb_sync_q[STAGES-1] & ~hb_sync_q[STAGES];
    req_d = rise & (vcount_async == V_TRIG_C);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hb_sync_q <= '0;
      req_q     <= 1'b0;
    end else begin
      hb_sync_q <= {hb_sync_q[STAGES-1:0], hblank_async};
      req_q     <= req_d;
    end
  end

  assign frame_req = req_q;

  // R5
  single_cycle_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);

endmodule

// File: rtl/vga_fifo_scanout.sv
module vga_fifo_scanout #(
  parameter int unsigned PIX_W      = vga_scan_pkg::PIX_W,
  parameter int unsigned FIFO_DEPTH = 1024,
  parameter int unsigned SYNC_STG   = 2,
  parameter int unsigned H_ACT      = 640,
  parameter int unsigned H_FP       = 16,
  parameter int unsigned H_SW       = 96,
  parameter int unsigned H_BP       = 48,
  parameter int unsigned V_ACT      = 480,
  parameter int unsigned V_FP       = 10,
  parameter int unsigned V_SW       = 2,
  parameter int unsigned V_BP       = 33
) (
  input  logic             clk_sys,
  input  logic             clk_pix,
  input  logic             rst_n,
  input  logic             px_wr_en,
  input  logic [PIX_W-1:0] px_wr_data,
  output logic             px_wr_full,
  output logic             frame_req,
  output logic             hsync_n,
  output logic             vsync_n,
  output logic             video_de,
  output logic [PIX_W-1:0] pixel,
  output logic             underflow
);

  localparam int unsigned V_TOT  = V_ACT + V_FP + V_SW + V_BP;
  localparam int unsigned VW     = $clog2(V_TOT);
  localparam int unsigned V_TRIG = V_ACT + V_FP + V_SW - 1;

  logic             sys_rst_n, pix_rst_n;
  logic [PIX_W-1:0] q_data;
  logic             q_empty, q_pop, hblank;
  logic [VW-1:0]    vcount;

  vga_rst_sync #(.STAGES(2)) u_rst_sys (.clk(clk_sys), .arst_n(rst_n), .rst_n(sys_rst_n));
  vga_rst_sync #(.STAGES(2)) u_rst_pix (.clk(clk_pix), .arst_n(rst_n), .rst_n(pix_rst_n));

  vga_async_fifo #(.W(PIX_W), .DEPTH(FIFO_DEPTH), .SYNC(SYNC_STG)) u_fifo (
    .wclk(clk_sys), .wrst_n(sys_rst_n), .wr_en(px_wr_en), .wr_data(px_wr_data),
    .wr_full(px_wr_full),
    .rclk(clk_pix), .rrst_n(pix_rst_n), .rd_en(q_pop), .rd_data(q_data),
    .rd_empty(q_empty)
  );

  vga_raster_timing #(
    .W(PIX_W), .H_ACT(H_ACT), .H_FP(H_FP), .H_SW(H_SW), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SW(V_SW), .V_BP(V_BP)
  ) u_timing (
    .clk(clk_pix), .rst_n(pix_rst_n), .fifo_data(q_data), .fifo_empty(q_empty),
    .fifo_pop(q_pop), .hsync_n(hsync_n), .vsync_n(vsync_n), .video_de(video_de),
    .pixel(pixel), .underflow(underflow), .hblank(hblank), .vcount(vcount)
  );

  vga_frame_request #(.STAGES(SYNC_STG), .VW(VW), .V_TRIG(V_TRIG)) u_req (
    .clk(clk_sys), .rst_n(sys_rst_n), .hblank_async(hblank), .vcount_async(vcount),
    .frame_req(frame_req)
  );

endmodule

// File: tb/sim_vga_fifo_scanout.sv
`timescale 1ns/100ps
module sim_vga_fifo_scanout;

  localparam int HA = 8, HFP = 2, HS = 3, HBP = 2;
  localparam int VA = 4, VFP = 1, VS = 2, VBP = 1;
  localparam int HT = HA + HFP + HS + HBP;
  localparam int VT = VA + VFP + VS + VBP;
  localparam int FR = HT * VT;
  localparam int VTRIG = VA + VFP + VS - 1;
  localparam int NPIX = HA * VA;
  localparam int LAST_F = 4;
  localparam int SHORT_N = 20;

  logic clk_sys = 0, clk_pix = 0, rst_n = 0;
  logic px_wr_en = 0;
  logic [15:0] px_wr_data = '0;
  logic px_wr_full, frame_req, hsync_n, vsync_n, video_de, underflow;
  logic [15:0] pixel;

  int checks = 0, fails = 0;
  int edges = 0, nreq = 0;
  int cur_h = -1, cur_v = -1;
  bit prev_req = 0, done = 0, uf_seen = 0;

  always #4   clk_sys = ~clk_sys;
  always #6.5 clk_pix = ~clk_pix;

  vga_fifo_scanout #(
    .FIFO_DEPTH(16), .SYNC_STG(2),
    .H_ACT(HA), .H_FP(HFP), .H_SW(HS), .H_BP(HBP),
    .V_ACT(VA), .V_FP(VFP), .V_SW(VS), .V_BP(VBP)
  ) u0 (.*);

  function automatic logic [15:0] pval(int f, int i);
    return 16'(f * 4099 + i * 97 + 5);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk_pix) if (rst_n) edges <= edges + 1;

  // pixel-side sweep of every clock
  always @(negedge clk_pix) begin
    if (rst_n && !done) begin
      if (edges < 3) begin
        chk(hsync_n && vsync_n && !video_de && pixel == 0, "R8 rst-release", {hsync_n, vsync_n, video_de}, 3'b110);
      end else begin
        int a, f, w, h, v, idx;
        bit e_de, e_hs, e_vs;
        logic [15:0] e_pix;
        a = edges - 3 + VTRIG * HT;
        if (a >= (LAST_F + 2) * FR) done = 1;
        else begin
          f = a / FR - 1; w = a % FR; h = w % HT; v = w / HT;
          cur_h = h; cur_v = v;
          e_de = (h < HA) && (v < VA);
          e_hs = !(h >= HA + HFP && h < HA + HFP + HS);
          e_vs = !(v >= VA + VFP && v < VA + VFP + VS);
          idx = v * HA + h;
          e_pix = 16'h0;
          if (e_de && f >= 0) begin
            if (f == LAST_F && idx >= SHORT_N) uf_seen = 1;
            else e_pix = pval(f, idx);
          end
          chk(hsync_n == e_hs, "R1 hsync", hsync_n, e_hs);
          chk(vsync_n == e_vs, "R2 vsync", vsync_n, e_vs);
          chk(video_de == e_de, "R3 de", video_de, e_de);
          if (e_de && !(f == LAST_F && idx >= SHORT_N))
            chk(pixel == e_pix, f[0] ? "R6 burst pixel" : "R3 paced pixel", pixel, e_pix);
          else if (e_de)
            chk(pixel == 0, "R7 black on empty", pixel, 0);
          else
            chk(pixel == 0, "R4 blank black", pixel, 0);
          chk(underflow == uf_seen, "R7 underflow flag", underflow, uf_seen);
        end
      end
    end
  end

  // request pulse monitor
  always @(negedge clk_sys) begin
    if (rst_n && !done) begin
      if (frame_req) begin
        nreq++;
        chk(!prev_req, "R5 single cycle", 1, 0);
        chk(cur_v == VTRIG && cur_h >= HA, "R5 position", cur_v * 100 + cur_h, VTRIG * 100 + HA);
      end
      prev_req = frame_req;
    end
  end

  task automatic write_frame(input int f, input int n, input bit paced);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_sys);
      while (px_wr_full) begin
        px_wr_en = 0;
        @(negedge clk_sys);
      end
      px_wr_en = 1;
      px_wr_data = pval(f, i);
      if (paced && i[0]) begin
        @(negedge clk_sys);
        px_wr_en = 0;
      end
    end
    @(negedge clk_sys);
    px_wr_en = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk_pix);
    chk(hsync_n && vsync_n && !video_de && pixel == 0 && !underflow && !frame_req,
        "R8 reset state", {hsync_n, vsync_n, video_de, underflow, frame_req}, 5'b11000);
    @(negedge clk_pix);
    rst_n = 1;
    fork
      begin
        for (int f = 0; f <= LAST_F; f++) begin
          wait (nreq > f);
          write_frame(f, (f == LAST_F) ? SHORT_N : NPIX, !f[0]);
        end
        wait (done);
      end
      begin
        #200000;
        fails++; checks++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    // R5: one request at start plus one per finished frame
    chk(nreq == LAST_F + 2, "R5 request count", nreq, LAST_F + 2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule